// File: doc/BRIEF.md
# Interrupt Recognition Timing Unit

This unit sits beside the cycle sequencer of a small 8-bit pipelined processor. It decides whether a level-sensitive, maskable interrupt request is serviced at the end of the current instruction. If it is, the cycle that would otherwise fetch the next opcode starts the vector sequence instead. Each cycle the unit registers the request together with the interrupt-disable flag.

The sequencer reports three things for the current instruction. It marks the instruction's final cycle, and it says whether that instruction is a conditional branch. For a branch it also reports whether the branch is taken and whether it crosses a page. At each final cycle the unit selects one earlier sample as the poll point. Ordinary instructions use the sample from two cycles before the end. A taken branch without a page crossing uses the sample from one cycle earlier than that. The chosen sample is latched into a pending flag, and the pending flag drives a one-cycle strobe in the first cycle of the next instruction.

Top module: `irq_recog_unit`

## Requirements
- R1: Let cycle L be the cycle in which lastCycle is high, for an instruction that is not a conditional branch. takeIrq is high in cycle L+1 exactly when, during cycle L-2, irqReq was high and irqDisable was low. For example, in a 4-cycle instruction (positions 0..3), a request that first appears in position 2 or 3 is not serviced at that boundary. It is serviced at the following boundary if it is still present.
- R2: For a conditional branch with brTaken high and pageCross low in its final cycle L, takeIrq in cycle L+1 follows the irqReq/irqDisable sample of cycle L-3. A request that first appears in cycle L-2 is therefore not serviced at that boundary.
- R3: For a conditional branch with brTaken low, the poll point is cycle L-2, as in R1.
- R4: For a taken branch that crosses a page (brTaken and pageCross both high), the poll point is cycle L-2, counted back from its own final cycle.
- R5: If irqDisable is high during the poll cycle, no strobe follows, whatever the level of irqReq. If the request is still high and enabled at a later poll point, it is serviced at that later boundary.
- R6: A request that is removed before the poll cycle is not serviced. A request that is present in the poll cycle is serviced even if it is removed afterwards.
- R7: takeIrq is high for a single cycle, and it is high only in a cycle that directly follows a cycle with lastCycle high.
- R8: rst is synchronous and active high. takeIrq is low in the cycle after any clock edge that samples rst high. The first instruction boundary after reset is released never raises takeIrq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irqReq | input | 1 | Level-sensitive maskable interrupt request |
| irqDisable | input | 1 | Interrupt-disable flag from the status register |
| lastCycle | input | 1 | High in the final cycle of the current instruction |
| isBranch | input | 1 | Current instruction is a conditional branch |
| brTaken | input | 1 | Branch condition holds (meaningful when isBranch is high) |
| pageCross | input | 1 | Taken branch target lies in another page |
| takeIrq | output | 1 | One-cycle strobe: replace the next opcode fetch with the vector sequence |

## Verification
The properties assume that every instruction lasts at least two cycles, so lastCycle is never high in two consecutive cycles. They also assume that isBranch, brTaken and pageCross are valid during the final cycle. A further assumption is that the sequencer starts the vector sequence, holding irqDisable high, whenever takeIrq fires. The stimulus is a cycle-by-cycle model of the sequencer that builds instructions of two to four cycles and follows each serviced interrupt with a short vector sequence under irqDisable. The model drives the branch flags for the whole of each branch instruction and never raises lastCycle twice in a row.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;

  // Strobes passed from the poll control to the sample datapath.
  typedef struct packed {
    logic poll;     // this cycle is an armed instruction end: latch the poll result
    logic lateWin;  // use the earlier (taken-branch) sample
  } pollCtrl_t;

endpackage

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_recog_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lastCycle,
  input  logic      isBranch,
  input  logic      brTaken,
  input  logic      pageCross,
  output pollCtrl_t ctrl
);

  // Cleared by reset; set once the first instruction after reset has ended.
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (lastCycle) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    ctrl.poll    = lastCycle & armed;
    ctrl.lateWin = isBranch & brTaken & ~pageCross;
  end

endmodule

// File: rtl/irq_poll_dp.sv
module irq_poll_dp
  import irq_recog_pkg::*;
#(
  parameter int POLL_LEAD = 2  // cycles before the instruction end for the normal poll
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      irqReq,
  input  logic      irqDisable,
  input  pollCtrl_t ctrl,
  output logic      takeIrq
);

  // hist[k], read during cycle n, holds the enabled request of cycle n-1-k.
  localparam int NORM_IDX = POLL_LEAD - 1;
  localparam int LATE_IDX = POLL_LEAD;
  localparam int DEPTH    = POLL_LEAD + 1;

  logic hist [DEPTH];
  logic pend;
  logic pollBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist[0] <= 1'b0;
    end else begin
      hist[0] <= irqReq & ~irqDisable;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        hist[g] <= 1'b0;
      end else begin
        hist[g] <= hist[g-1];
      end
    end
  end

  always_comb begin
    pollBit = ctrl.lateWin ? hist[LATE_IDX] : hist[NORM_IDX];
  end

  // The pending flag lives for exactly one cycle: the would-be opcode fetch.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else begin
      pend <= ctrl.poll & pollBit;
    end
  end

  assign takeIrq = pend;

endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit
  import irq_recog_pkg::*;
#(
  parameter int POLL_LEAD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irqReq,
  input  logic irqDisable,
  input  logic lastCycle,
  input  logic isBranch,
  input  logic brTaken,
  input  logic pageCross,
  output logic takeIrq
);

  pollCtrl_t ctrl;

  irq_poll_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .lastCycle (lastCycle),
    .isBranch  (isBranch),
    .brTaken   (brTaken),
    .pageCross (pageCross),
    .ctrl      (ctrl)
  );

  irq_poll_dp #(.POLL_LEAD(POLL_LEAD)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .irqReq     (irqReq),
    .irqDisable (irqDisable),
    .ctrl       (ctrl),
    .takeIrq    (takeIrq)
  );

endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk (
  input logic clk,
  input logic rst,
  input logic irqReq,
  input logic irqDisable,
  input logic lastCycle,
  input logic isBranch,
  input logic brTaken,
  input logic pageCross,
  input logic takeIrq
);

  // Tracked independently: an instruction has ended since reset.
  logic seenEnd;
  logic lateKind;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenEnd <= 1'b0;
    end else if (lastCycle) begin
      seenEnd <= 1'b1;
    end
  end

  assign lateKind = isBranch && brTaken && !pageCross;

  // R1, R3, R4: normal poll point two cycles before the end
  p_normal_poll_r1: assert property (@(posedge clk) disable iff (rst)
    (lastCycle && seenEnd && !lateKind) |=>
      (takeIrq == ($past(irqReq, 3) && !$past(irqDisable, 3))));

  // R2: taken branch without page crossing polls one cycle earlier
  p_late_poll_r2: assert property (@(posedge clk) disable iff (rst)
    (lastCycle && seenEnd && lateKind) |=>
      (takeIrq == ($past(irqReq, 4) && !$past(irqDisable, 4))));

  // R7: single-cycle strobe
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    takeIrq |=> !takeIrq);

  // R7: strobe only right after an instruction end
  p_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> $past(lastCycle));

  // R8: first boundary after reset never strobes
  p_first_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (lastCycle && !seenEnd) |=> !takeIrq);

endmodule

bind irq_recog_unit irq_recog_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .irqReq     (irqReq),
  .irqDisable (irqDisable),
  .lastCycle  (lastCycle),
  .isBranch   (isBranch),
  .brTaken    (brTaken),
  .pageCross  (pageCross),
  .takeIrq    (takeIrq)
);

// File: tb/irq_recog_unit_tb_top.sv
module irq_recog_unit_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irqReq = 1'b0;
  logic irqDisable = 1'b0;
  logic lastCycle = 1'b0;
  logic isBranch = 1'b0;
  logic brTaken = 1'b0;
  logic pageCross = 1'b0;
  logic takeIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_recog_unit dut_i (
    .clk        (clk),
    .rst        (rst),
    .irqReq     (irqReq),
    .irqDisable (irqDisable),
    .lastCycle  (lastCycle),
    .isBranch   (isBranch),
    .brTaken    (brTaken),
    .pageCross  (pageCross),
    .takeIrq    (takeIrq)
  );

  // One instruction: length, branch flags, per-position request and disable
  // masks (bit k = position k), expected strobe at its boundary, tag code.
  typedef struct packed {
    logic [2:0] len;
    logic       br;
    logic       tk;
    logic       pc;
    logic [7:0] req;
    logic [7:0] dis;
    logic       exp;
    logic [3:0] tag;
  } instr_t;

  localparam int N_INSTR = 23;
  localparam logic [27:0] TBL [N_INSTR] = '{
    {3'd2, 3'b000, 8'h03, 8'h00, 1'b0, 4'd8, 1'b0},  // first after reset
    {3'd4, 3'b000, 8'h0F, 8'h00, 1'b1, 4'd1, 1'b0},  // request held
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},  // vector seq
    {3'd4, 3'b000, 8'h0C, 8'h00, 1'b0, 4'd1, 1'b0},  // request in pos 2,3: deferred
    {3'd2, 3'b000, 8'h03, 8'h00, 1'b1, 4'd1, 1'b0},  // serviced one later
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},
    {3'd3, 3'b110, 8'h07, 8'h00, 1'b0, 4'd2, 1'b0},  // taken branch, too late
    {3'd2, 3'b000, 8'h00, 8'h00, 1'b1, 4'd1, 1'b0},
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},
    {3'd2, 3'b000, 8'h02, 8'h00, 1'b0, 4'd1, 1'b0},
    {3'd3, 3'b110, 8'h00, 8'h00, 1'b1, 4'd6, 1'b0},  // taken branch, early poll hit
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},
    {3'd2, 3'b000, 8'h02, 8'h00, 1'b0, 4'd1, 1'b0},
    {3'd2, 3'b100, 8'h00, 8'h00, 1'b1, 4'd3, 1'b0},  // not-taken branch
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},
    {3'd4, 3'b111, 8'h02, 8'h00, 1'b1, 4'd4, 1'b0},  // taken, page cross
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},
    {3'd4, 3'b000, 8'h0F, 8'h02, 1'b0, 4'd5, 1'b0},  // disabled at poll
    {3'd2, 3'b000, 8'h00, 8'h00, 1'b1, 4'd5, 1'b0},  // later poll catches it
    {3'd3, 3'b000, 8'h00, 8'h07, 1'b0, 4'd1, 1'b0},
    {3'd4, 3'b000, 8'h01, 8'h00, 1'b0, 4'd6, 1'b0},  // request gone before poll
    {3'd2, 3'b000, 8'h00, 8'h00, 1'b0, 4'd6, 1'b0},
    {3'd2, 3'b000, 8'h00, 8'h00, 1'b0, 4'd1, 1'b0}
  };

  function automatic string tagName(input logic [3:0] code);
    case (code)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic exp, input string tag);
    nChecks++;
    if (takeIrq !== exp) begin
      nFails++;
      $display("FAIL %s: takeIrq=%b expected=%b at %0t", tag, takeIrq, exp, $time);
    end
  endtask

  // Runs one instruction; checks the strobe in every one of its cycles.
  task automatic runInstr(input instr_t e, input logic expFirst,
                          input logic [3:0] tagFirst, input logic rstLast);
    for (int k = 0; k < int'(e.len); k++) begin
      @(posedge clk);
      #2;
      rst        = rstLast && (k == int'(e.len) - 1);
      irqReq     = e.req[k];
      irqDisable = e.dis[k];
      lastCycle  = (k == int'(e.len) - 1);
      isBranch   = e.br;
      brTaken    = e.tk;
      pageCross  = e.pc;
      #6;
      if (k == 0) check(expFirst, tagName(tagFirst));
      else        check(1'b0, "R7");
    end
  endtask

  initial begin
    logic prevExp;
    logic [3:0] prevTag;
    instr_t e;

    // R8: reset state
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #8;
      check(1'b0, "R8");
    end

    prevExp = 1'b0;
    prevTag = 4'd8;
    for (int i = 0; i < N_INSTR; i++) begin
      e = instr_t'(TBL[i][27:1]);
      runInstr(e, prevExp, prevTag, 1'b0);
      prevExp = e.exp;
      prevTag = e.tag;
    end

    // R8: reset at the edge ending a polled instruction kills the strobe
    e = instr_t'({3'd4, 3'b000, 8'h0F, 8'h00, 1'b0, 4'd8});
    runInstr(e, prevExp, prevTag, 1'b1);
    // R8: first instruction after reset cannot strobe even with request held
    e = instr_t'({3'd2, 3'b000, 8'h03, 8'h00, 1'b0, 4'd8});
    runInstr(e, 1'b0, 4'd8, 1'b0);
    e = instr_t'({3'd2, 3'b000, 8'h03, 8'h00, 1'b1, 4'd1});
    runInstr(e, 1'b0, 4'd8, 1'b0);
    // R1: the second boundary after reset is serviced
    @(posedge clk);
    #2;
    irqReq = 1'b0;
    irqDisable = 1'b1;
    lastCycle = 1'b0;
    isBranch = 1'b0;
    #6;
    check(1'b1, "R1");
    @(posedge clk);
    #8;
    check(1'b0, "R7");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule